// File: doc/BRIEF.md
# Multi-Mode Down-Counter Timer Channel

This block is a single timer channel built around a 16-bit down counter. Software writes a preset value one byte at a time, and a control byte selects the operating behaviour. The counter steps down on rising edges of an external count-clock input, and an external gate input qualifies it. Five behaviours use the same counter: a sticky level timeout, a one-tick strobe, a gate-retriggered one-shot, a periodic rate generator and a software-set duty-cycle waveform.

The channel drives a true output, its complement, a timeout status flag and an active-low interrupt contribution that a wrapper can combine with other channels. The count-clock and gate inputs are synchronised to the system clock, so every count event is one pulse of one system clock cycle. Software reads the count through a holding register. When latched reads are enabled, that register freezes the upper byte at the moment the lower byte is read.

Register map (2-bit address): 0 = preset low byte on write, count low byte on read. 1 = preset high byte on write, count high byte on read. 2 = control, which can be written and read back. 3 = unused; writes are ignored and reads return 0. Control byte: bits [2:0] mode (1 timeout, 2 strobe, 3 one-shot, 4 rate, 5 duty; 0, 6 and 7 halt counting). Bit 3 is gate polarity (1 = gate active high). Bit 4 enables latched reads, bit 5 enables the interrupt and bit 6 is run. Bit 7 is spare.

Top module: `ctc_channel`

## Requirements
- R1: After reset, out_true is 0, out_comp is 1, timeout_flag is 0 and irq_n is 1.
- R2: Writes to address 0 and then address 1 form the 16-bit preset (low byte, then high byte). The write to address 1 loads the preset into the counter on the next count-clock rising edge. The count reads back as a low byte (address 0) and a high byte (address 1).
- R3: With run set (control bit 6) and the gate active, each count-clock rising edge lowers the count by exactly one. Between count events the count does not change.
- R4: Control bit 3 sets gate polarity: 1 means a high gate is active, 0 means a low gate is active. In modes 1, 2, 4 and 5, an inactive gate or a cleared run bit freezes the count.
- R5: In mode 1 (timeout), out_true goes high when the count steps from 1 to 0. It stays high, and the count stays at 0.
- R6: In mode 2 (strobe), out_true goes high when the count steps to 0 and returns low on the next count event, so the pulse is exactly one count-clock period wide.
- R7: In mode 3 (one-shot), the gate becoming active loads the preset and starts counting, whatever the gate level is afterwards. out_true goes high at zero. If the gate becomes active again before zero, the preset reloads.
- R8: In mode 4 (rate), when a count event finds the count at 1, the counter reloads the preset and out_true goes high for one count period. The output therefore repeats every preset count events.
- R9: In mode 5 (duty), out_true stays high for as many count events as the preset low byte gives and low for as many as the high byte gives. The cycle repeats, and a preset load starts it in the high phase.
- R10: timeout_flag is set when the count reaches 0 (modes 1 to 3), on each reload (mode 4) and at the end of each high phase (mode 5). irq_n is low exactly when the flag and control bit 5 are both set. A control write clears the flag and drives out_true low.
- R11: With control bit 4 set, reading address 0 captures the whole count, and the next read of address 1 returns the captured high byte while counting continues. With bit 4 clear, both bytes read the live count.
- R12: out_comp is always the inverse of out_true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is active |
| cnt_clk | input | 1 | Count-clock input; counting happens on rising edges |
| gate_in | input | 1 | Gate input with programmable polarity |
| out_true | output | 1 | Channel output |
| out_comp | output | 1 | Complement of out_true |
| timeout_flag | output | 1 | Timeout status |
| irq_n | output | 1 | Active-low interrupt contribution |

## Verification
The embedded assertions check, on every cycle, the following: the count does not change between count events; timeout and one-shot status rises only with the counter at zero; a timeout output stays high until a control write or reload; a strobe drops after one count event; and the holding register stays frozen while latched reads are enabled. Some behaviours can only be shown by the bench's scenarios. These are the exact waveform shapes of the rate and duty modes, the retrigger reload, the effect of gate polarity on counting and the byte-ordered latched read, which the bench checks through the bus and the output pins.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
   typedef enum logic [2:0] {
      MD_HALT    = 3'd0,
      MD_TIMEOUT = 3'd1,
      MD_STROBE  = 3'd2,
      MD_ONESHOT = 3'd3,
      MD_RATE    = 3'd4,
      MD_DUTY    = 3'd5,
      MD_RSV6    = 3'd6,
      MD_RSV7    = 3'd7
   } ctc_mode_e;

   typedef struct packed {
      logic      spare;
      logic      run;
      logic      irq_en;
      logic      latch_rd;
      logic      gate_hi;
      ctc_mode_e mode;
   } ctc_ctrl_t;

   localparam logic [1:0] A_LO   = 2'd0;
   localparam logic [1:0] A_HI   = 2'd1;
   localparam logic [1:0] A_CTRL = 2'd2;
endpackage

// File: rtl/ctc_sync.sv
module ctc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("ctc_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ctc_bus_regs.sv
module ctc_bus_regs
   import ctc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              load_ack,
   output logic [2*BYTE_W-1:0] preset,
   output ctc_ctrl_t         ctrl,
   output logic              ctrl_wr,
   output logic              load_pend
);
   localparam int CNT_W = 2 * BYTE_W;

   logic wr_lo, wr_hi;
   assign wr_lo   = bus_wr && (bus_addr == A_LO);
   assign wr_hi   = bus_wr && (bus_addr == A_HI);
   assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset    <= '0;
         ctrl      <= '0;
         load_pend <= 1'b0;
      end else begin
         if (wr_lo) preset[BYTE_W-1:0]     <= bus_wdata;
         if (wr_hi) preset[CNT_W-1:BYTE_W] <= bus_wdata;
         if (ctrl_wr) ctrl <= ctc_ctrl_t'(bus_wdata[7:0]);
         if (wr_hi)         load_pend <= 1'b1;
         else if (load_ack) load_pend <= 1'b0;
      end
   end

   // R2: a high-byte write always leaves a load pending
   AST_HI_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> load_pend); // R2
endmodule

// File: rtl/ctc_core.sv
module ctc_core
   import ctc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cclk_s,
   input  logic                gate_s,
   input  ctc_mode_e           mode,
   input  logic                run,
   input  logic                gate_hi,
   input  logic                ctrl_wr,
   input  logic [2*BYTE_W-1:0] preset,
   input  logic                load_pend,
   output logic [2*BYTE_W-1:0] count,
   output logic                out_q,
   output logic                status,
   output logic                load_ack
);
   localparam int CNT_W = 2 * BYTE_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic cclk_q, act_q, armed;
   logic tick, gate_act, trig, run_ok;
   logic [CNT_W-1:0] lo_ext, hi_ext;

   assign tick     = cclk_s && !cclk_q;
   assign gate_act = (gate_s == gate_hi);
   assign trig     = (mode == MD_ONESHOT) && run && gate_act && !act_q;
   assign run_ok   = run && ((mode == MD_ONESHOT) ? armed : gate_act);
   assign load_ack = !ctrl_wr && (trig || (tick && load_pend));
   assign lo_ext   = {{BYTE_W{1'b0}}, preset[BYTE_W-1:0]};
   assign hi_ext   = {{BYTE_W{1'b0}}, preset[CNT_W-1:BYTE_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cclk_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         cclk_q <= cclk_s;
         act_q  <= gate_act;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         out_q  <= 1'b0;
         status <= 1'b0;
         armed  <= 1'b0;
      end else if (ctrl_wr) begin
         out_q  <= 1'b0;
         status <= 1'b0;
         armed  <= 1'b0;
      end else if (trig) begin
         count <= preset;
         out_q <= 1'b0;
         armed <= 1'b1;
      end else if (tick) begin
         if (load_pend) begin
            count <= (mode == MD_DUTY) ? lo_ext : preset;
            out_q <= (mode == MD_DUTY);
            armed <= 1'b0;
         end else begin
            if (mode == MD_STROBE || mode == MD_RATE) out_q <= 1'b0;
            if (run_ok) begin
               case (mode)
                  MD_TIMEOUT, MD_STROBE, MD_ONESHOT: begin
                     if (count != '0) count <= count - ONE;
                     if (count == ONE) begin
                        out_q  <= 1'b1;
                        status <= 1'b1;
                        if (mode == MD_ONESHOT) armed <= 1'b0;
                     end
                  end
                  MD_RATE: begin
                     if (count == ONE) begin
                        count  <= preset;
                        out_q  <= 1'b1;
                        status <= 1'b1;
                     end else if (count != '0) begin
                        count <= count - ONE;
                     end
                  end
                  MD_DUTY: begin
                     if (count <= ONE) begin
                        if (out_q) begin
                           out_q  <= 1'b0;
                           status <= 1'b1;
                           count  <= hi_ext;
                        end else begin
                           out_q <= 1'b1;
                           count <= lo_ext;
                        end
                     end else begin
                        count <= count - ONE;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !trig) |=> $stable(count)); // R3
   AST_TIMEOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_TIMEOUT && out_q && !ctrl_wr && !load_ack) |=> out_q); // R5
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_STROBE && out_q && tick && !ctrl_wr) |=> !out_q); // R6
   AST_STATUS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status) && (mode == MD_TIMEOUT || mode == MD_STROBE || mode == MD_ONESHOT))
      |-> (count == '0)); // R10
endmodule

// File: rtl/ctc_readback.sv
module ctc_readback
   import ctc_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_rd,
   input  logic [1:0]          bus_addr,
   input  logic [2*BYTE_W-1:0] count,
   input  ctc_ctrl_t           ctrl,
   output logic [BYTE_W-1:0]   bus_rdata
);
   localparam int CNT_W = 2 * BYTE_W;

   logic [CNT_W-1:0] hold;
   logic             lo_rd;

   assign lo_rd = bus_rd && (bus_addr == A_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hold <= '0;
      else if (!ctrl.latch_rd) hold <= count;
      else if (lo_rd)         hold <= count;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (bus_addr)
            A_LO:   bus_rdata = count[BYTE_W-1:0];
            A_HI:   bus_rdata = ctrl.latch_rd ? hold[CNT_W-1:BYTE_W]
                                              : count[CNT_W-1:BYTE_W];
            A_CTRL: bus_rdata = BYTE_W'(ctrl);
            default: bus_rdata = '0;
         endcase
      end
   end

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.latch_rd && !lo_rd) |=> $stable(hold)); // R11
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
   import ctc_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              cnt_clk,
   input  logic              gate_in,
   output logic              out_true,
   output logic              out_comp,
   output logic              timeout_flag,
   output logic              irq_n
);
   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("ctc_channel: control layout needs BYTE_W of 8");
      end
   endgenerate

   logic [1:0]       sync_q;
   logic [CNT_W-1:0] preset, count;
   ctc_ctrl_t        ctrl;
   logic             ctrl_wr, load_pend, load_ack, out_q, status;

   ctc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({gate_in, cnt_clk}), .q(sync_q));

   ctc_bus_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .load_ack(load_ack), .preset(preset),
      .ctrl(ctrl), .ctrl_wr(ctrl_wr), .load_pend(load_pend));

   ctc_core #(.BYTE_W(BYTE_W)) u_core (
      .clk(clk), .rst_n(rst_n), .cclk_s(sync_q[0]), .gate_s(sync_q[1]),
      .mode(ctrl.mode), .run(ctrl.run), .gate_hi(ctrl.gate_hi),
      .ctrl_wr(ctrl_wr), .preset(preset), .load_pend(load_pend),
      .count(count), .out_q(out_q), .status(status), .load_ack(load_ack));

   ctc_readback #(.BYTE_W(BYTE_W)) u_rb (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .count(count), .ctrl(ctrl), .bus_rdata(bus_rdata));

   assign out_true     = out_q;
   assign out_comp     = ~out_q;
   assign timeout_flag = status;
   assign irq_n        = ~(status && ctrl.irq_en);

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr) |=> irq_n); // R10
endmodule

// File: tb/ctc_channel_bench.sv
module ctc_channel_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cnt_clk = 1'b0, gate_in = 1'b1;
   logic       out_true, out_comp, timeout_flag, irq_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   typedef struct { int kind; logic [7:0] exp; string req; } item_t;
   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ctc_channel u_ctc_channel (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_clk(cnt_clk), .gate_in(gate_in), .out_true(out_true),
      .out_comp(out_comp), .timeout_flag(timeout_flag), .irq_n(irq_n));

   // monitor: pops expected items and compares with what the pins show
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sb.pop_front();
         case (it.kind)
            0: act = {7'd0, out_true};
            1: act = {7'd0, timeout_flag};
            2: act = {7'd0, irq_n};
            default: act = bus_rdata;
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
         end
         if (it.kind == 0) begin
            n_chk++;
            if (out_comp !== ~out_true) begin
               n_fail++;
               $display("FAIL R12 out_comp actual %b expected %b", out_comp, ~out_true);
            end
         end
      end
   end

   task automatic expect_item(int k, logic [7:0] e, string r);
      sb.push_back(item_t'{k, e, r});
      @(negedge clk); #1;
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [1:0] a, logic [7:0] e, string r);
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = a;
      expect_item(3, e, r);
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; cnt_clk = 1'b1;
         repeat (4) @(posedge clk);
         #1; cnt_clk = 1'b0;
         repeat (4) @(posedge clk);
      end
      #1;
   endtask

   task automatic set_gate(logic v);
      @(posedge clk); #1; gate_in = v;
      repeat (6) @(posedge clk);
      #1;
   endtask

   task automatic load16(logic [15:0] v);
      wr(2'd0, v[7:0]);
      wr(2'd1, v[15:8]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_item(0, 8'h00, "R1 out");
      expect_item(1, 8'h00, "R1 flag");
      expect_item(2, 8'h01, "R1 irq_n");

      // timeout mode, run, irq enable, gate active high
      wr(2'd2, 8'h69);
      load16(16'h0003);
      ticks(1);
      rd_chk(2'd0, 8'h03, "R2 load lo");
      rd_chk(2'd1, 8'h00, "R2 load hi");
      ticks(2);
      rd_chk(2'd0, 8'h01, "R3 decrement");
      expect_item(0, 8'h00, "R5 before zero");
      ticks(1);
      expect_item(0, 8'h01, "R5 at zero");
      expect_item(1, 8'h01, "R10 flag set");
      expect_item(2, 8'h00, "R10 irq asserted");
      ticks(1);
      rd_chk(2'd0, 8'h00, "R5 stays zero");
      expect_item(0, 8'h01, "R5 sticky");
      wr(2'd2, 8'h49);
      expect_item(1, 8'h00, "R10 ctrl write clears");
      expect_item(0, 8'h00, "R10 ctrl write drops out");
      expect_item(2, 8'h01, "R10 irq released");

      // gate polarity and run
      load16(16'h0005);
      ticks(1);
      set_gate(1'b0);
      ticks(2);
      rd_chk(2'd0, 8'h05, "R4 inactive gate freezes");
      wr(2'd2, 8'h41);
      ticks(2);
      rd_chk(2'd0, 8'h03, "R4 active-low gate counts");
      wr(2'd2, 8'h01);
      ticks(1);
      rd_chk(2'd0, 8'h03, "R4 run clear freezes");
      set_gate(1'b1);

      // latched read
      wr(2'd2, 8'h59);
      load16(16'h0102);
      ticks(1);
      rd_chk(2'd0, 8'h02, "R11 capture lo");
      ticks(3);
      rd_chk(2'd1, 8'h01, "R11 captured hi");
      rd_chk(2'd0, 8'hFF, "R11 second lo");
      rd_chk(2'd1, 8'h00, "R11 second hi");
      wr(2'd2, 8'h49);
      ticks(1);
      rd_chk(2'd0, 8'hFE, "R11 live lo");

      // strobe
      wr(2'd2, 8'h4A);
      load16(16'h0002);
      ticks(1);
      ticks(1);
      expect_item(0, 8'h00, "R6 before zero");
      ticks(1);
      expect_item(0, 8'h01, "R6 strobe high");
      expect_item(1, 8'h01, "R10 strobe flag");
      ticks(1);
      expect_item(0, 8'h00, "R6 strobe one tick");

      // rate generator
      wr(2'd2, 8'h6C);
      load16(16'h0003);
      ticks(1);
      ticks(2);
      expect_item(0, 8'h00, "R8 low between");
      ticks(1);
      expect_item(0, 8'h01, "R8 pulse");
      rd_chk(2'd0, 8'h03, "R8 reload");
      expect_item(2, 8'h00, "R10 rate irq");
      ticks(1);
      expect_item(0, 8'h00, "R8 pulse width");
      ticks(1);
      expect_item(0, 8'h00, "R8 still low");
      ticks(1);
      expect_item(0, 8'h01, "R8 period");

      // variable duty: high 2, low 3
      wr(2'd2, 8'h4D);
      load16(16'h0302);
      ticks(1);
      expect_item(0, 8'h01, "R9 starts high");
      ticks(1);
      expect_item(0, 8'h01, "R9 high phase");
      ticks(1);
      expect_item(0, 8'h00, "R9 low phase");
      expect_item(1, 8'h01, "R10 duty flag");
      rd_chk(2'd0, 8'h03, "R9 low count");
      ticks(2);
      expect_item(0, 8'h00, "R9 low held");
      ticks(1);
      expect_item(0, 8'h01, "R9 high again");
      rd_chk(2'd0, 8'h02, "R9 high count");

      // one-shot
      set_gate(1'b0);
      wr(2'd2, 8'h4B);
      load16(16'h0002);
      set_gate(1'b1);
      rd_chk(2'd0, 8'h02, "R7 trigger loads");
      expect_item(0, 8'h00, "R7 out low");
      ticks(1);
      rd_chk(2'd0, 8'h01, "R7 counting");
      set_gate(1'b0);
      set_gate(1'b1);
      rd_chk(2'd0, 8'h02, "R7 retrigger");
      ticks(1);
      expect_item(0, 8'h00, "R7 not yet");
      ticks(1);
      expect_item(0, 8'h01, "R7 fires");
      expect_item(1, 8'h01, "R10 oneshot flag");

      repeat (3) @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule